// File: doc/BRIEF.md
# Per-Thread Outstanding Address Tracker

This block decides whether a memory request may occupy a slot of a data-cache access unit. It holds a pool of access slots shared by all hardware threads and, for every thread, a small table of outstanding request addresses. Each table entry is tagged with the sequence number of the instruction that owns it. A request is compared only with the table of its own thread. The block grants a slot, or denies the request so that the pipeline retries later. A grant may record a new address entry.

When a slot is freed, the block releases the slot and removes one address entry that matches the address the slot was granted for. An instruction that was split across two cache lines may ask for a slot again without a valid address, and may free a slot whose address entry is already gone. Any other request without an address, and any other free that finds no entry, raises a protocol-fault pin.

The request port is a valid-qualified handshake with a response in the same cycle. `req_grant` acts as ready, and `req_deny` is the explicit back-pressure answer. Both are combinational in the cycle that `req_valid` is high. A denied request is not held inside the block: the requester drives it again in a later cycle. Table and pool updates take effect at the next rising clock edge. The free port has no back-pressure.

Top module: `oat_tracker`

## Requirements
- R1: A request is compared only with the address table of its own thread. The same address held by another thread never blocks it.
- R2: A request with a valid address that matches no entry of its thread is granted when a slot and a table entry are free. The address is recorded together with the request's sequence number.
- R3: A request whose address is outstanding in its thread under a different sequence number is denied.
- R4: A request whose address is outstanding in its thread under the same sequence number is granted a new slot, and no second entry is recorded. As a result, a later free of the second slot finds no entry once the first slot is freed.
- R5: When every slot is busy after any same-cycle free, every request is denied whatever its address check says.
- R6: When the thread's table (TBL_DEPTH entries) is full, a request for a new address is denied even with slots free. Repeat requests from the same sequence number are still granted.
- R7: A request with `req_addr_ok`=0 and `req_split`=0 is denied and drives `proto_fault`=1 in the same cycle. With `req_split`=1 it is granted a slot if one is free, and no entry is recorded.
- R8: Freeing a busy slot releases it and removes one entry of the slot's thread that matches the slot's address. That address can then be granted to another sequence number.
- R9: A free of a busy slot that finds no matching entry drives `proto_fault`=1 in the same cycle, unless the slot was granted with `req_split`=1.
- R10: A free and a request in the same cycle see the free first: the released slot and the released entry are available to that request.
- R11: `req_grant`/`req_deny` and `grant_slot` are valid in the request cycle. `grant_slot` is the lowest-numbered slot that is free after any same-cycle free.
- R12: After reset all slots and tables are empty. With no request and no free, `req_grant`, `req_deny` and `proto_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_tid | input | TID_W | Thread of the request |
| req_addr | input | ADDR_W | Request address |
| req_seq | input | SEQ_W | Sequence number of the requesting instruction |
| req_addr_ok | input | 1 | `req_addr` holds a valid address |
| req_split | input | 1 | Instruction is a line-crossing split access |
| free_valid | input | 1 | Release a slot this cycle |
| free_slot | input | SLOT_W | Slot to release |
| req_grant | output | 1 | Request granted (ready) |
| req_deny | output | 1 | Request refused, retry later |
| grant_slot | output | SLOT_W | Slot given to a granted request, 0 otherwise |
| proto_fault | output | 1 | Missing address on a non-split request, or missing entry on a non-split free |

## Verification
Grant, deny, slot index and fault all come out in the same cycle as the stimulus, with no register between input and output. The bench drives every input on the falling edge and samples one nanosecond later, well before the next rising edge. State effects (a recorded entry, a removed entry, a reused slot) appear only after that rising edge. Each of these is therefore checked with a follow-up request or free in a later cycle, and each such probe is also sampled in its own cycle.

// File: rtl/oat_pkg.sv
package oat_pkg;
  // Outcome of the request check, used for readability in the top level.
  typedef enum logic [2:0] {
    DEC_IDLE,
    DEC_GRANT_NEW,
    DEC_GRANT_REPEAT,
    DEC_GRANT_NOADDR,
    DEC_DENY_BUSY,
    DEC_DENY_NOSLOT,
    DEC_DENY_FULL,
    DEC_DENY_BADADDR
  } decision_e;
endpackage

// File: rtl/oat_addr_table.sv
module oat_addr_table #(
  parameter int ADDR_W = 32,
  parameter int SEQ_W  = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rm_en,
  input  logic [ADDR_W-1:0] rm_addr,
  output logic              rm_hit,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [SEQ_W-1:0]  chk_seq,
  output logic              hit_same,
  output logic              hit_other,
  output logic              full,
  input  logic              ins_en
);
  logic [DEPTH-1:0]  vld_q, rm_vec, eff_vld, ins_vec;
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [SEQ_W-1:0]  seq_q  [DEPTH];

  // Removal picks the first matching entry; applied before the check.
  always_comb begin
    logic found;
    found  = 1'b0;
    rm_vec = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && rm_en && vld_q[i] && addr_q[i] == rm_addr) begin
        rm_vec[i] = 1'b1;
        found     = 1'b1;
      end
    end
    rm_hit  = found;
    eff_vld = vld_q & ~rm_vec;
  end

  always_comb begin
    hit_same  = 1'b0;
    hit_other = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (eff_vld[i] && addr_q[i] == chk_addr) begin
        if (seq_q[i] == chk_seq) hit_same  = 1'b1;
        else                     hit_other = 1'b1;
      end
    end
  end

  always_comb begin
    logic taken;
    taken   = 1'b0;
    ins_vec = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!taken && !eff_vld[i]) begin
        ins_vec[i] = 1'b1;
        taken      = 1'b1;
      end
    end
    full = ~taken;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= eff_vld | (ins_en ? ins_vec : '0);
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (ins_en && ins_vec[i]) begin
        addr_q[i] <= chk_addr;
        seq_q[i]  <= chk_seq;
      end
    end
  end

  // R6: never insert into a table with no free entry
  a_r6_no_insert_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> !full);
  // R3: an address is never recorded twice in one thread
  a_r3_no_dup_insert: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> !(hit_same || hit_other));
  // R8: a removal without insertion shrinks the table by one
  a_r8_remove_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_hit && !ins_en) |=> $countones(vld_q) == $past($countones(vld_q)) - 1);
endmodule

// File: rtl/oat_slot_pool.sv
module oat_slot_pool #(
  parameter int NUM_SLOTS = 8,
  parameter int TID_W     = 1,
  parameter int ADDR_W    = 32,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rel_en,
  input  logic [SLOT_W-1:0] rel_slot,
  output logic              rel_busy,
  output logic [TID_W-1:0]  rel_tid,
  output logic [ADDR_W-1:0] rel_addr,
  output logic              rel_split,
  input  logic              alloc_en,
  input  logic [TID_W-1:0]  alloc_tid,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              alloc_split,
  output logic              avail,
  output logic [SLOT_W-1:0] alloc_slot
);
  logic [NUM_SLOTS-1:0] busy_q, rel_vec, eff_busy;
  logic [TID_W-1:0]     tid_q   [NUM_SLOTS];
  logic [ADDR_W-1:0]    addr_q  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] split_q;

  always_comb begin
    rel_vec = '0;
    if (rel_en) rel_vec[rel_slot] = 1'b1;
    rel_busy  = busy_q[rel_slot];
    rel_tid   = tid_q[rel_slot];
    rel_addr  = addr_q[rel_slot];
    rel_split = split_q[rel_slot];
    eff_busy  = busy_q & ~rel_vec;
  end

  // Lowest free slot after the same-cycle release.
  always_comb begin
    avail      = 1'b0;
    alloc_slot = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!avail && !eff_busy[i]) begin
        avail      = 1'b1;
        alloc_slot = SLOT_W'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= '0;
      split_q <= '0;
    end else begin
      busy_q <= eff_busy;
      if (alloc_en) begin
        busy_q[alloc_slot]  <= 1'b1;
        split_q[alloc_slot] <= alloc_split;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      tid_q[alloc_slot]  <= alloc_tid;
      addr_q[alloc_slot] <= alloc_addr;
    end
  end

  // R5: no allocation when the pool is exhausted
  a_r5_alloc_needs_slot: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> avail);
  // R11: an allocated slot is busy on the following cycle
  a_r11_alloc_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |=> busy_q[$past(alloc_slot)]);
  // R10: a released slot that is not re-allocated becomes free
  a_r10_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_en && !(alloc_en && alloc_slot == rel_slot)) |=> !busy_q[$past(rel_slot)]);
endmodule

// File: rtl/oat_tracker.sv
module oat_tracker #(
  parameter int NUM_THREADS = 2,
  parameter int NUM_SLOTS   = 8,
  parameter int TBL_DEPTH   = 8,
  parameter int ADDR_W      = 32,
  parameter int SEQ_W       = 16,
  localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [TID_W-1:0]  req_tid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SEQ_W-1:0]  req_seq,
  input  logic              req_addr_ok,
  input  logic              req_split,
  input  logic              free_valid,
  input  logic [SLOT_W-1:0] free_slot,
  output logic              req_grant,
  output logic              req_deny,
  output logic [SLOT_W-1:0] grant_slot,
  output logic              proto_fault
);
  import oat_pkg::*;

  logic              rel_busy, rel_split, avail;
  logic [TID_W-1:0]  rel_tid;
  logic [ADDR_W-1:0] rel_addr;
  logic [SLOT_W-1:0] alloc_slot;
  logic [NUM_THREADS-1:0] rm_en_t, rm_hit_t, same_t, other_t, full_t, ins_en_t;
  logic sel_same, sel_other, sel_full, record;
  decision_e dec;

  oat_slot_pool #(.NUM_SLOTS(NUM_SLOTS), .TID_W(TID_W), .ADDR_W(ADDR_W)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .rel_en(free_valid), .rel_slot(free_slot), .rel_busy(rel_busy),
    .rel_tid(rel_tid), .rel_addr(rel_addr), .rel_split(rel_split),
    .alloc_en(req_grant), .alloc_tid(req_tid), .alloc_addr(req_addr),
    .alloc_split(req_split), .avail(avail), .alloc_slot(alloc_slot)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign rm_en_t[t]  = free_valid && rel_busy && (rel_tid == TID_W'(t));
    assign ins_en_t[t] = record && (req_tid == TID_W'(t));
    oat_addr_table #(.ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .DEPTH(TBL_DEPTH)) u_tbl (
      .clk(clk), .rst_n(rst_n),
      .rm_en(rm_en_t[t]), .rm_addr(rel_addr), .rm_hit(rm_hit_t[t]),
      .chk_addr(req_addr), .chk_seq(req_seq),
      .hit_same(same_t[t]), .hit_other(other_t[t]), .full(full_t[t]),
      .ins_en(ins_en_t[t])
    );
  end

  always_comb begin
    sel_same  = 1'b0;
    sel_other = 1'b0;
    sel_full  = 1'b0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (req_tid == TID_W'(t)) begin
        sel_same  = same_t[t];
        sel_other = other_t[t];
        sel_full  = full_t[t];
      end
    end
  end

  // Priority: bad address, slot pool, split-without-address, then table.
  always_comb begin
    if (!req_valid)                       dec = DEC_IDLE;
    else if (!req_addr_ok && !req_split)  dec = DEC_DENY_BADADDR;
    else if (!avail)                      dec = DEC_DENY_NOSLOT;
    else if (!req_addr_ok)                dec = DEC_GRANT_NOADDR;
    else if (sel_other)                   dec = DEC_DENY_BUSY;
    else if (sel_same)                    dec = DEC_GRANT_REPEAT;
    else if (sel_full)                    dec = DEC_DENY_FULL;
    else                                  dec = DEC_GRANT_NEW;
  end

  always_comb begin
    req_grant   = (dec == DEC_GRANT_NEW) || (dec == DEC_GRANT_REPEAT) ||
                  (dec == DEC_GRANT_NOADDR);
    req_deny    = (dec == DEC_DENY_BADADDR) || (dec == DEC_DENY_NOSLOT) ||
                  (dec == DEC_DENY_BUSY) || (dec == DEC_DENY_FULL);
    record      = (dec == DEC_GRANT_NEW);
    grant_slot  = req_grant ? alloc_slot : '0;
    proto_fault = (dec == DEC_DENY_BADADDR) ||
                  (free_valid && rel_busy && !(|rm_hit_t) && !rel_split);
  end

  // R12: a request is answered with at most one of grant and deny
  a_r12_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_grant && req_deny));
  // R11: every valid request gets an answer in its own cycle
  a_r11_answered: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_grant || req_deny));
  // R5: exhausted pool means deny
  a_r5_deny_without_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !avail) |-> req_deny);
  // R7: missing address on a non-split request is refused and flagged
  a_r7_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_addr_ok && !req_split) |-> (req_deny && proto_fault));
  // R12: an idle cycle raises nothing
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !free_valid) |-> !(req_grant || req_deny || proto_fault));
endmodule

// File: tb/test_oat_tracker.sv
module test_oat_tracker;
  localparam int SLOT_W = 3;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_addr_ok = 1'b0, req_split = 1'b0, free_valid = 1'b0;
  logic        req_tid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_seq = '0;
  logic [SLOT_W-1:0] free_slot = '0;
  logic        req_grant, req_deny, proto_fault;
  logic [SLOT_W-1:0] grant_slot;
  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  // Table depth reduced to 4 so that a full table can coexist with free slots.
  oat_tracker #(.NUM_THREADS(2), .NUM_SLOTS(8), .TBL_DEPTH(4)) i_oat_tracker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tid(req_tid),
    .req_addr(req_addr), .req_seq(req_seq), .req_addr_ok(req_addr_ok),
    .req_split(req_split), .free_valid(free_valid), .free_slot(free_slot),
    .req_grant(req_grant), .req_deny(req_deny), .grant_slot(grant_slot),
    .proto_fault(proto_fault)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One cycle: drive at falling edge, sample 1 ns later, let rising edge commit.
  task automatic step(input bit rv, input bit tid, input int addr, input int seq,
                      input bit ok, input bit split, input bit fv, input int fslot,
                      input bit eg, input bit ed, input int eslot, input bit ef,
                      input string tag);
    @(negedge clk);
    req_valid = rv; req_tid = tid; req_addr = addr; req_seq = 16'(seq);
    req_addr_ok = ok; req_split = split; free_valid = fv; free_slot = SLOT_W'(fslot);
    #1;
    chk({tag, " grant"}, int'(req_grant), int'(eg));
    chk({tag, " deny"}, int'(req_deny), int'(ed));
    if (eg) chk({tag, " slot"}, int'(grant_slot), eslot);
    chk({tag, " fault"}, int'(proto_fault), int'(ef));
    @(posedge clk);
    #1;
    req_valid = 1'b0; free_valid = 1'b0;
  endtask

  task automatic req_new(input bit tid, input int addr, input int seq,
                         input bit eg, input int eslot, input string tag);
    step(1, tid, addr, seq, 1, 0, 0, 0, eg, !eg, eslot, 0, tag);
  endtask

  task automatic do_free(input int slot, input bit ef, input string tag);
    step(0, 0, 0, 0, 0, 0, 1, slot, 0, 0, 0, ef, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset_idle();
    do_reset();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12 idle after reset");
  endtask

  task automatic t_basic();
    do_reset();
    req_new(0, 'h100, 1, 1, 0, "R2 R11 first grant slot0");
    req_new(0, 'h200, 2, 1, 1, "R2 second grant slot1");
    req_new(0, 'h100, 3, 0, 0, "R3 other seq denied");
    req_new(1, 'h100, 5, 1, 2, "R1 other thread granted");
  endtask

  task automatic t_repeat();
    do_reset();
    req_new(0, 'h180, 7, 1, 0, "R4 first");
    req_new(0, 'h180, 7, 1, 1, "R4 same seq regrant");
    do_free(0, 0, "R8 free entry found");
    do_free(1, 1, "R4 R9 second free finds no entry");
  endtask

  task automatic t_split();
    do_reset();
    req_new(0, 'h300, 1, 1, 0, "R2 split base");
    step(1, 0, 'h340, 2, 0, 1, 0, 0, 1, 0, 1, 0, "R7 split without address granted");
    do_free(1, 0, "R9 split free tolerated");
    req_new(0, 'h340, 9, 1, 1, "R7 no entry recorded for split");
  endtask

  task automatic t_remove();
    do_reset();
    req_new(0, 'h500, 1, 1, 0, "R8 setup");
    req_new(0, 'h500, 2, 0, 0, "R3 blocked");
    do_free(0, 0, "R8 free");
    req_new(0, 'h500, 2, 1, 0, "R8 address released");
  endtask

  task automatic t_bad_addr();
    do_reset();
    step(1, 0, 'h600, 1, 0, 0, 0, 0, 0, 1, 0, 1, "R7 missing address faults");
  endtask

  task automatic t_pool_full();
    do_reset();
    for (int i = 0; i < 4; i++) req_new(0, 'h10 * (i + 1), 1 + i, 1, i, "R2 fill t0");
    for (int i = 0; i < 4; i++) req_new(1, 'h10 * (i + 1), 11 + i, 1, 4 + i, "R1 fill t1");
    step(1, 0, 'h700, 20, 0, 1, 0, 0, 0, 1, 0, 0, "R5 no slot denied");
    step(1, 0, 'h700, 20, 0, 1, 1, 3, 1, 0, 3, 0, "R10 same-cycle free reused");
  endtask

  task automatic t_table_full();
    do_reset();
    for (int i = 0; i < 4; i++) req_new(0, 'h40 + 'h10 * i, 1 + i, 1, i, "R6 fill table");
    req_new(0, 'h900, 9, 0, 0, "R6 full table denied");
    req_new(0, 'h40, 1, 1, 4, "R6 repeat still granted");
    req_new(1, 'h900, 9, 1, 5, "R1 other thread unaffected");
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset_idle();
    t_basic();
    t_repeat();
    t_split();
    t_remove();
    t_bad_addr();
    t_pool_full();
    t_table_full();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule